// File: doc/BRIEF.md
# UART Interrupt Combiner with Delayed Receive Interrupt

This block merges the status events of a UART into one interrupt line. Two kinds of source feed it. Per-event sources each produce a single-cycle pulse: a drained transmit FIFO, a completed receive character (good or errored), a break, and an emptied transmit shift register. Level sources stay high while their condition lasts: the transmit FIFO being below half full and the receive FIFO being at least half full. All sources are ORed and registered onto `irq_out`.

An optional delayed receive mode is provided to reduce interrupt load. In this mode each received character restarts an idle timer. The timer counts bit-time ticks supplied by the baud generator. The receive interrupt fires only when the timer runs out with no newer character. The timeout is four character times plus four bit times, and all of these are parameters. Break characters have their own enable, and that enable takes precedence over the delay. While the receive FIFO level interrupt is active, any delayed receive interrupt that is still pending is dropped, because software will read the character through the FIFO anyway.

Top module: `uart_irq_combiner`

## Requirements
- R1: A cycle with `ev_txfifo_drained`, `en_tx_irq` and `tx_enable` all high makes `irq_out` high in the next cycle. With `tx_enable` low the event has no effect.
- R2: With `en_rx_delay` low, a cycle where `ev_rx_char` or `ev_rx_err` is high together with `en_rx_irq` and `rx_enable` makes `irq_out` high in the next cycle. With `en_rx_irq` low neither event has an effect.
- R3: `irq_out` is high in the cycle after every cycle in which `en_txfifo_irq`, `tx_enable` and `txfifo_below_half` are all high. It is low again once any of them drops and no other source is active.
- R4: `irq_out` is high in the cycle after every cycle in which `en_rxfifo_irq`, `rx_enable` and `rxfifo_at_half` are all high. Without `rx_enable` the level has no effect.
- R5: With `en_rx_delay`, `en_rx_irq` and `rx_enable` high, a received character gives no immediate interrupt. `irq_out` pulses for exactly one cycle once DLY_CHARS*BITS_PER_CHAR+DLY_BITS ticks of `bit_tick` have followed the character's cycle.
- R6: In delayed mode a new character restarts the full timeout. No interrupt fires for the earlier character.
- R7: With `en_brk_irq` and `rx_enable` high, `ev_rx_break` makes `irq_out` high in the next cycle, whether `en_rx_delay` is set or not.
- R8: With `en_brk_irq` low, a break raises an interrupt only when `en_rx_delay` is low and `en_rx_irq` and `rx_enable` are high. With `en_rx_delay` set it raises none.
- R9: A cycle in which the receive FIFO level interrupt of R4 is active cancels any pending delayed receive interrupt, so the timeout later produces no pulse.
- R10: A cycle with `ev_shift_empty` and `en_shift_irq` high makes `irq_out` high in the next cycle. With `en_shift_irq` low the event has no effect.
- R11: `irq_out` is low while `rst_n` is low. It is driven from a register, so it changes only one clock edge after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_tx_irq | input | 1 | Enable for the interrupt on a drained transmit FIFO |
| en_rx_irq | input | 1 | Enable for the per-character receive interrupt |
| en_txfifo_irq | input | 1 | Enable for the transmit FIFO level interrupt |
| en_rxfifo_irq | input | 1 | Enable for the receive FIFO level interrupt |
| en_rx_delay | input | 1 | Selects the delayed receive interrupt mode |
| en_brk_irq | input | 1 | Enable for the break interrupt |
| en_shift_irq | input | 1 | Enable for the shift-register-empty interrupt |
| tx_enable | input | 1 | Transmitter enabled |
| rx_enable | input | 1 | Receiver enabled |
| ev_rx_char | input | 1 | Pulse: a character was stored correctly |
| ev_rx_err | input | 1 | Pulse: a character finished with a parity, framing or overrun error |
| ev_rx_break | input | 1 | Pulse: a break was received |
| ev_txfifo_drained | input | 1 | Pulse: the transmit FIFO went from holding data to empty |
| ev_shift_empty | input | 1 | Pulse: the transmit shift register went from non-empty to empty |
| txfifo_below_half | input | 1 | Level: the transmit FIFO is less than half full |
| rxfifo_at_half | input | 1 | Level: at least half of the receive FIFO is occupied |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with BITS_PER_CHAR set to 2 and keeps the default four characters plus four bits. This gives a timeout of 12 ticks. With `bit_tick` held high, the whole delayed window, the cycle just before expiry, the expiry cycle and the cycle after it can be walked one by one. The same short window lets the restart and cancel tests place a second character or a FIFO level pulse in the middle of a running timeout. Each case then still takes only a few dozen cycles.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Number of bit-time ticks of silence before a delayed receive interrupt.
  function automatic int dly_ticks(input int chars, input int bits_per_char, input int extra_bits);
    return chars * bits_per_char + extra_bits;
  endfunction

  // Counter width able to hold the value n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/uart_irq_evt.sv
module uart_irq_evt (
  input  logic en_tx_irq,
  input  logic en_rx_irq,
  input  logic en_rx_delay,
  input  logic en_brk_irq,
  input  logic en_shift_irq,
  input  logic tx_enable,
  input  logic rx_enable,
  input  logic ev_rx_char,
  input  logic ev_rx_err,
  input  logic ev_rx_break,
  input  logic ev_txfifo_drained,
  input  logic ev_shift_empty,
  output logic tx_pulse,
  output logic rx_pulse,
  output logic brk_pulse,
  output logic shift_pulse
);
  logic rx_done;

  always_comb begin
    rx_done     = ev_rx_char | ev_rx_err;
    tx_pulse    = en_tx_irq & tx_enable & ev_txfifo_drained;
    // Immediate receive interrupt only outside delayed mode.
    rx_pulse    = en_rx_irq & rx_enable & ~en_rx_delay & rx_done;
    // Break: its own enable always wins; otherwise it falls back to the
    // receive enable, but only when delayed mode is off.
    brk_pulse   = rx_enable & ev_rx_break & (en_brk_irq | (en_rx_irq & ~en_rx_delay));
    shift_pulse = en_shift_irq & ev_shift_empty;
  end
endmodule

// File: rtl/uart_irq_level.sv
module uart_irq_level (
  input  logic en_txfifo_irq,
  input  logic en_rxfifo_irq,
  input  logic tx_enable,
  input  logic rx_enable,
  input  logic txfifo_below_half,
  input  logic rxfifo_at_half,
  output logic txlvl,
  output logic rxlvl
);
  always_comb begin
    txlvl = en_txfifo_irq & tx_enable & txfifo_below_half;
    rxlvl = en_rxfifo_irq & rx_enable & rxfifo_at_half;
  end
endmodule

// File: rtl/uart_irq_rxdelay.sv
module uart_irq_rxdelay #(
  parameter int TMO   = 44,
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,      // delayed mode active and receive interrupts enabled
  input  logic rx_done,  // a character completed
  input  logic tick,     // one bit time elapsed
  input  logic flush,    // receive FIFO level interrupt active
  output logic pending,
  output logic fire
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TMO);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             restart;

  always_comb begin
    restart = arm & rx_done;
    fire    = pending & arm & ~flush & ~restart & tick & (cnt == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (!arm || flush) begin
      pending <= 1'b0;
    end else if (restart) begin
      pending <= 1'b1;
      cnt     <= LOAD;
    end else if (fire) begin
      pending <= 1'b0;
    end else if (pending && tick) begin
      cnt     <= cnt - ONE;
    end
  end
endmodule

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner #(
  parameter int BITS_PER_CHAR = 10,
  parameter int DLY_CHARS     = 4,
  parameter int DLY_BITS      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_tx_irq,
  input  logic en_rx_irq,
  input  logic en_txfifo_irq,
  input  logic en_rxfifo_irq,
  input  logic en_rx_delay,
  input  logic en_brk_irq,
  input  logic en_shift_irq,
  input  logic tx_enable,
  input  logic rx_enable,
  input  logic ev_rx_char,
  input  logic ev_rx_err,
  input  logic ev_rx_break,
  input  logic ev_txfifo_drained,
  input  logic ev_shift_empty,
  input  logic txfifo_below_half,
  input  logic rxfifo_at_half,
  input  logic bit_tick,
  output logic irq_out
);
  import uart_irq_pkg::*;

  localparam int TMO   = dly_ticks(DLY_CHARS, BITS_PER_CHAR, DLY_BITS);
  localparam int CNT_W = cnt_width(TMO);

  // Named internal events, visible to the bound checker.
  logic tx_pulse_w, rx_pulse_w, brk_pulse_w, shift_pulse_w;
  logic txlvl_w, rxlvl_w;
  logic dly_pending_w, dly_fire_w;
  logic dly_arm_w;
  logic irq_next;

  uart_irq_evt i_evt (
    .en_tx_irq         (en_tx_irq),
    .en_rx_irq         (en_rx_irq),
    .en_rx_delay       (en_rx_delay),
    .en_brk_irq        (en_brk_irq),
    .en_shift_irq      (en_shift_irq),
    .tx_enable         (tx_enable),
    .rx_enable         (rx_enable),
    .ev_rx_char        (ev_rx_char),
    .ev_rx_err         (ev_rx_err),
    .ev_rx_break       (ev_rx_break),
    .ev_txfifo_drained (ev_txfifo_drained),
    .ev_shift_empty    (ev_shift_empty),
    .tx_pulse          (tx_pulse_w),
    .rx_pulse          (rx_pulse_w),
    .brk_pulse         (brk_pulse_w),
    .shift_pulse       (shift_pulse_w)
  );

  uart_irq_level i_lvl (
    .en_txfifo_irq     (en_txfifo_irq),
    .en_rxfifo_irq     (en_rxfifo_irq),
    .tx_enable         (tx_enable),
    .rx_enable         (rx_enable),
    .txfifo_below_half (txfifo_below_half),
    .rxfifo_at_half    (rxfifo_at_half),
    .txlvl             (txlvl_w),
    .rxlvl             (rxlvl_w)
  );

  assign dly_arm_w = en_rx_delay & en_rx_irq & rx_enable;

  uart_irq_rxdelay #(.TMO(TMO), .CNT_W(CNT_W)) i_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (dly_arm_w),
    .rx_done (ev_rx_char | ev_rx_err),
    .tick    (bit_tick),
    .flush   (rxlvl_w),
    .pending (dly_pending_w),
    .fire    (dly_fire_w)
  );

  assign irq_next = tx_pulse_w | rx_pulse_w | brk_pulse_w | shift_pulse_w
                  | txlvl_w | rxlvl_w | dly_fire_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= irq_next;
  end
endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker (
  input logic clk,
  input logic rst_n,
  input logic en_tx_irq,
  input logic en_rx_irq,
  input logic en_txfifo_irq,
  input logic en_rxfifo_irq,
  input logic en_rx_delay,
  input logic en_brk_irq,
  input logic en_shift_irq,
  input logic tx_enable,
  input logic rx_enable,
  input logic ev_rx_char,
  input logic ev_rx_err,
  input logic ev_rx_break,
  input logic ev_txfifo_drained,
  input logic ev_shift_empty,
  input logic txfifo_below_half,
  input logic rxfifo_at_half,
  input logic rxlvl_w,
  input logic dly_pending_w,
  input logic dly_fire_w,
  input logic irq_out
);
  a_r1_tx_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (en_tx_irq && tx_enable && ev_txfifo_drained) |=> irq_out);

  a_r2_rx_now: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rx_irq && rx_enable && !en_rx_delay && (ev_rx_char || ev_rx_err)) |=> irq_out);

  a_r3_txlvl: assert property (@(posedge clk) disable iff (!rst_n)
    (en_txfifo_irq && tx_enable && txfifo_below_half) |=> irq_out);

  a_r4_rxlvl: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rxfifo_irq && rx_enable && rxfifo_at_half) |=> irq_out);

  a_r5_fire_needs_delay: assert property (@(posedge clk) disable iff (!rst_n)
    dly_fire_w |-> (en_rx_delay && en_rx_irq && rx_enable));

  a_r5_fire_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    dly_fire_w |=> irq_out);

  a_r7_break: assert property (@(posedge clk) disable iff (!rst_n)
    (en_brk_irq && rx_enable && ev_rx_break) |=> irq_out);

  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    rxlvl_w |=> !dly_pending_w);

  a_r10_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (en_shift_irq && ev_shift_empty) |=> irq_out);
endmodule

bind uart_irq_combiner uart_irq_checker i_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .en_tx_irq         (en_tx_irq),
  .en_rx_irq         (en_rx_irq),
  .en_txfifo_irq     (en_txfifo_irq),
  .en_rxfifo_irq     (en_rxfifo_irq),
  .en_rx_delay       (en_rx_delay),
  .en_brk_irq        (en_brk_irq),
  .en_shift_irq      (en_shift_irq),
  .tx_enable         (tx_enable),
  .rx_enable         (rx_enable),
  .ev_rx_char        (ev_rx_char),
  .ev_rx_err         (ev_rx_err),
  .ev_rx_break       (ev_rx_break),
  .ev_txfifo_drained (ev_txfifo_drained),
  .ev_shift_empty    (ev_shift_empty),
  .txfifo_below_half (txfifo_below_half),
  .rxfifo_at_half    (rxfifo_at_half),
  .rxlvl_w           (rxlvl_w),
  .dly_pending_w     (dly_pending_w),
  .dly_fire_w        (dly_fire_w),
  .irq_out           (irq_out)
);

// File: tb/test_uart_irq_combiner.sv
module test_uart_irq_combiner;
  localparam int BPC   = 2;
  localparam int NCHR  = 4;
  localparam int NBIT  = 4;
  localparam int LIMIT = NBIT + NCHR * BPC;  // bench's own view of the timeout

  // Stimulus bit positions; bit 17 holds the expected irq_out.
  localparam logic [17:0] TI = 18'h1 << 0,  RI = 18'h1 << 1,  TF = 18'h1 << 2;
  localparam logic [17:0] RF = 18'h1 << 3,  DI = 18'h1 << 4,  BE = 18'h1 << 5;
  localparam logic [17:0] SE = 18'h1 << 6,  TE = 18'h1 << 7,  RE = 18'h1 << 8;
  localparam logic [17:0] CH = 18'h1 << 9,  ER = 18'h1 << 10, BK = 18'h1 << 11;
  localparam logic [17:0] TD = 18'h1 << 12, SH = 18'h1 << 13, TL = 18'h1 << 14;
  localparam logic [17:0] RH = 18'h1 << 15, TK = 18'h1 << 16, EX = 18'h1 << 17;

  localparam int NV = 16;
  localparam logic [17:0] VEC [NV] = '{
    TI|TE|TD|EX,   // R1
    TI|TD,         // R1 transmitter off
    RI|RE|CH|EX,   // R2 good char
    RI|RE|ER|EX,   // R2 errored char
    RE|CH|ER,      // R2 enable off
    TF|TE|TL|EX,   // R3
    TF|TL,         // R3 transmitter off
    RF|RE|RH|EX,   // R4
    RF|RH,         // R4 receiver off
    SE|SH|EX,      // R10
    SH,            // R10 disabled
    RI|RE|BK|EX,   // R8 fallback to RI
    BE|RE|BK|EX,   // R7
    RE|BK,         // R8 nothing enabled
    TF|TE|TL|EX,   // R3 level again
    18'h0          // R3 released
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_tx_irq, en_rx_irq, en_txfifo_irq, en_rxfifo_irq, en_rx_delay;
  logic en_brk_irq, en_shift_irq, tx_enable, rx_enable;
  logic ev_rx_char, ev_rx_err, ev_rx_break, ev_txfifo_drained, ev_shift_empty;
  logic txfifo_below_half, rxfifo_at_half, bit_tick;
  logic irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_irq_combiner #(.BITS_PER_CHAR(BPC), .DLY_CHARS(NCHR), .DLY_BITS(NBIT)) i_uart_irq_combiner (
    .clk(clk), .rst_n(rst_n),
    .en_tx_irq(en_tx_irq), .en_rx_irq(en_rx_irq), .en_txfifo_irq(en_txfifo_irq),
    .en_rxfifo_irq(en_rxfifo_irq), .en_rx_delay(en_rx_delay), .en_brk_irq(en_brk_irq),
    .en_shift_irq(en_shift_irq), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .ev_rx_char(ev_rx_char), .ev_rx_err(ev_rx_err), .ev_rx_break(ev_rx_break),
    .ev_txfifo_drained(ev_txfifo_drained), .ev_shift_empty(ev_shift_empty),
    .txfifo_below_half(txfifo_below_half), .rxfifo_at_half(rxfifo_at_half),
    .bit_tick(bit_tick), .irq_out(irq_out)
  );

  task automatic drive(input logic [17:0] v);
    en_tx_irq = v[0];  en_rx_irq = v[1];  en_txfifo_irq = v[2];  en_rxfifo_irq = v[3];
    en_rx_delay = v[4]; en_brk_irq = v[5]; en_shift_irq = v[6];  tx_enable = v[7];
    rx_enable = v[8];  ev_rx_char = v[9]; ev_rx_err = v[10];     ev_rx_break = v[11];
    ev_txfifo_drained = v[12]; ev_shift_empty = v[13];
    txfifo_below_half = v[14]; rxfifo_at_half = v[15]; bit_tick = v[16];
  endtask

  task automatic chk(input string rid, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_out=%b expected %b at t=%0t", rid, act, exp, $time);
    end
  endtask

  // Apply v for one cycle, then compare the registered output.
  task automatic step(input logic [17:0] v, input string rid, input logic exp);
    drive(v);
    @(negedge clk);
    chk(rid, irq_out, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected <= 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    drive(TF|TE|TL);
    repeat (3) @(negedge clk);
    chk("R11 reset", irq_out, 1'b0);
    drive(18'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle", irq_out, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i] & ~EX, $sformatf("vec%0d", i), VEC[i][17]);
    end

    // R11: no combinational path; the output follows one edge later.
    drive(TI|TE|TD);
    #1 chk("R11 latency same cycle", irq_out, 1'b0);
    @(negedge clk);
    chk("R11 latency next cycle", irq_out, 1'b1);
    step(18'h0, "R11 clear", 1'b0);

    // R5: delayed interrupt after LIMIT ticks, one cycle wide.
    step(DI|RI|RE|CH|TK, "R5 no immediate", 1'b0);
    for (int k = 1; k <= LIMIT + 1; k++) begin
      step(DI|RI|RE|TK, $sformatf("R5 tick %0d", k), (k == LIMIT));
    end

    // R5: without ticks the timer does not advance.
    step(DI|RI|RE|CH, "R5 armed", 1'b0);
    for (int k = 0; k < 3 * LIMIT; k++) begin
      step(DI|RI|RE, "R5 no tick", 1'b0);
    end
    step(RI|RE, "R5 disarm", 1'b0);

    // R6: second character restarts the window.
    step(DI|RI|RE|CH|TK, "R6 first char", 1'b0);
    for (int k = 1; k <= 5; k++) step(DI|RI|RE|TK, "R6 before restart", 1'b0);
    step(DI|RI|RE|ER|TK, "R6 second char", 1'b0);
    for (int k = 1; k <= LIMIT + 1; k++) begin
      step(DI|RI|RE|TK, $sformatf("R6 tick %0d", k), (k == LIMIT));
    end

    // R9: FIFO level cancels the pending delayed interrupt.
    step(DI|RI|RE|CH|TK, "R9 char", 1'b0);
    step(DI|RI|RE|TK, "R9 wait", 1'b0);
    step(DI|RI|RE|RF|RH|TK, "R9 level", 1'b1);
    for (int k = 0; k < LIMIT + 2; k++) begin
      step(DI|RI|RE|TK, "R9 cancelled", 1'b0);
    end

    // R7 / R8 under delayed mode.
    step(DI|RI|RE|BE|BK, "R7 break with delay", 1'b1);
    step(DI|RI|RE|BK, "R8 break silent with delay", 1'b0);
    for (int k = 0; k < LIMIT + 2; k++) begin
      step(DI|RI|RE|TK, "R8 no timer from break", 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule